// File: doc/BRIEF.md
# Keypad Autorepeat Event Generator

This block sits between a key-matrix scanner with debouncing and the event FIFO that software drains. It watches the debounced key events and a level that says whether any key is still down. When a key stays down long enough, it asks the FIFO to store one dedicated repeat code. Every later repeat follows at a shorter, fixed interval. The code of the held key is never stored again. Only the shared repeat code is pushed, and only one per interval however many keys are down.

All timing is counted in debounce ticks, one for each pulse of the debounce-tick input. A configuration byte sets three things: an enable bit, a field for the initial delay and a field for the repeat interval. Any new key event cancels the running sequence. A press, or a release that leaves other keys down, starts the delay again from zero. The FIFO accepts every request, so the write interface has a request strobe and a data byte but no back-pressure.

Top module: `autorepeatGen`

## Requirements
- R1: Bit 7 of `cfgByte` is the enable. While it is 0, `fifoWrReq` is never asserted, even with keys held and ticks arriving.
- R2: After a press event with the enable set, the first repeat code is requested on the (D+1)*8-th debounce tick, where D is `cfgByte[3:0]`. That gives 8 to 128 ticks.
- R3: After each repeat code, the next is requested on the (R+1)*4-th following debounce tick, where R is `cfgByte[6:4]`. That gives 4 to 32 ticks.
- R4: Each request is a pulse of `fifoWrReq` lasting one cycle, with `fifoWrData` equal to 0x7E. At most one request is made per interval, whatever the number of keys held.
- R5: A press event in the middle of a sequence cancels it. The next repeat code comes only after the full initial delay, counted from that press.
- R6: A release event with `keyHeld`=1 restarts the sequence from the full initial delay. A release event with `keyHeld`=0 ends the sequence, and no further repeat codes are requested.
- R7: Clearing the enable aborts a running sequence and clears its count. Setting the enable again does not resume the sequence. A new key event is needed to start one.
- R8: A debounce tick in the same cycle as a key event is not counted.
- R9: `fifoWrReq` rises in the clock cycle that follows the edge at which the completing debounce tick was sampled.
- R10: After reset, `fifoWrReq` is 0 and no sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgByte | input | 8 | Bit 7 is the enable, bits 6:4 the interval field, bits 3:0 the delay field |
| debTick | input | 1 | Debounce-cycle tick, high for one cycle |
| keyEvtValid | input | 1 | A debounced key event occurs this cycle |
| keyEvtRelease | input | 1 | Qualifies `keyEvtValid`: 1 for a release, 0 for a press |
| keyHeld | input | 1 | At least one key is held, including the effect of this cycle's event |
| fifoWrReq | output | 1 | Request to push a repeat code into the event FIFO |
| fifoWrData | output | 8 | Repeat code 0x7E while the request is high, else 0 |

## Verification
Every result appears exactly one register stage after the debounce tick that completes a count. The request is therefore due in the cycle after the edge that sampled that tick. A key event or a change of the enable suppresses a request from the following cycle on. The bench drives inputs just after the rising edge and samples on the falling edge. A behavioural model advances at the same rising edges, and its expected request is compared every cycle. Counts of delivered requests are also checked at tick boundaries, against the delays and intervals computed from the configuration fields.

// File: rtl/arPkg.sv
package arPkg;
  typedef enum logic {PH_DELAY = 1'b0, PH_REPEAT = 1'b1} arPhase_t;

  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic emit;
  } arStrobes_t;
endpackage

// File: rtl/arCtrl.sv
module arCtrl
  import arPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       debTick,
  input  logic       keyEvtValid,
  input  logic       keyEvtRelease,
  input  logic       keyHeld,
  input  logic       hit,
  output arPhase_t   phase,
  output arStrobes_t strobes
);
  logic armed;
  logic startSeq, stopSeq, countEn;

  // A press, or a release that leaves keys down, begins a fresh sequence.
  assign startSeq = enable & keyEvtValid & (~keyEvtRelease | keyHeld);
  assign stopSeq  = ~startSeq & (~enable | keyEvtValid | ~keyHeld);
  assign countEn  = armed & debTick & ~startSeq & ~stopSeq;

  always_comb begin
    strobes.emit   = countEn & hit;
    strobes.incCnt = countEn & ~hit;
    strobes.clrCnt = startSeq | stopSeq | (countEn & hit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
      phase <= PH_DELAY;
    end else if (startSeq) begin
      armed <= 1'b1;
      phase <= PH_DELAY;
    end else if (stopSeq) begin
      armed <= 1'b0;
      phase <= PH_DELAY;
    end else if (strobes.emit) begin
      phase <= PH_REPEAT;
    end
  end
endmodule

// File: rtl/arDatapath.sv
module arDatapath
  import arPkg::*;
#(
  parameter int         DELAY_W     = 4,
  parameter int         RATE_W      = 3,
  parameter int         DELAY_UNIT  = 8,
  parameter int         RATE_UNIT   = 4,
  parameter int         CNT_W       = 8,
  parameter int         DATA_W      = 8,
  parameter logic [7:0] REPEAT_CODE = 8'h7E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DELAY_W-1:0] delayField,
  input  logic [RATE_W-1:0]  rateField,
  input  arPhase_t          phase,
  input  arStrobes_t        strobes,
  output logic              hit,
  output logic              wrReq,
  output logic [DATA_W-1:0] wrData
);
  localparam int TGT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [TGT_W-1:0] delayTgt, rateTgt, target, nextCnt;

  assign delayTgt = TGT_W'((int'(delayField) + 1) * DELAY_UNIT);
  assign rateTgt  = TGT_W'((int'(rateField) + 1) * RATE_UNIT);
  assign target   = (phase == PH_REPEAT) ? rateTgt : delayTgt;
  assign nextCnt  = {1'b0, cnt} + 1'b1;
  assign hit      = (nextCnt == target);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      wrReq <= 1'b0;
    end else begin
      wrReq <= strobes.emit;
      if (strobes.clrCnt)      cnt <= '0;
      else if (strobes.incCnt) cnt <= nextCnt[CNT_W-1:0];
    end
  end

  assign wrData = wrReq ? DATA_W'(REPEAT_CODE) : '0;
endmodule

// File: rtl/autorepeatGen.sv
module autorepeatGen #(
  parameter int         DELAY_W     = 4,
  parameter int         RATE_W      = 3,
  parameter int         DELAY_UNIT  = 8,
  parameter int         RATE_UNIT   = 4,
  parameter int         DATA_W      = 8,
  parameter logic [7:0] REPEAT_CODE = 8'h7E,
  localparam int        CFG_W       = DELAY_W + RATE_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CFG_W-1:0]  cfgByte,
  input  logic              debTick,
  input  logic              keyEvtValid,
  input  logic              keyEvtRelease,
  input  logic              keyHeld,
  output logic              fifoWrReq,
  output logic [DATA_W-1:0] fifoWrData
);
  import arPkg::*;

  localparam int MAX_DELAY = (2 ** DELAY_W) * DELAY_UNIT;
  localparam int MAX_RATE  = (2 ** RATE_W) * RATE_UNIT;
  localparam int MAX_TGT   = (MAX_DELAY > MAX_RATE) ? MAX_DELAY : MAX_RATE;
  localparam int CNT_W     = $clog2(MAX_TGT + 1);

  arPhase_t   phase;
  arStrobes_t strobes;
  logic       hit;

  arCtrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (cfgByte[CFG_W-1]),
    .debTick      (debTick),
    .keyEvtValid  (keyEvtValid),
    .keyEvtRelease(keyEvtRelease),
    .keyHeld      (keyHeld),
    .hit          (hit),
    .phase        (phase),
    .strobes      (strobes)
  );

  arDatapath #(
    .DELAY_W    (DELAY_W),
    .RATE_W     (RATE_W),
    .DELAY_UNIT (DELAY_UNIT),
    .RATE_UNIT  (RATE_UNIT),
    .CNT_W      (CNT_W),
    .DATA_W     (DATA_W),
    .REPEAT_CODE(REPEAT_CODE)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .delayField(cfgByte[DELAY_W-1:0]),
    .rateField (cfgByte[DELAY_W+RATE_W-1:DELAY_W]),
    .phase     (phase),
    .strobes   (strobes),
    .hit       (hit),
    .wrReq     (fifoWrReq),
    .wrData    (fifoWrData)
  );
endmodule

// File: rtl/arChecker.sv
module arChecker #(
  parameter int         CFG_W       = 8,
  parameter int         DATA_W      = 8,
  parameter logic [7:0] REPEAT_CODE = 8'h7E
) (
  input logic              clk,
  input logic              rstN,
  input logic [CFG_W-1:0]  cfgByte,
  input logic              debTick,
  input logic              keyEvtValid,
  input logic              fifoWrReq,
  input logic [DATA_W-1:0] fifoWrData
);
  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!cfgByte[CFG_W-1]) |-> !fifoWrReq);

  assert_code_value_R4: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrReq |-> (fifoWrData == DATA_W'(REPEAT_CODE)));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrReq |=> !fifoWrReq);

  assert_event_cancels_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(keyEvtValid) |-> !fifoWrReq);

  assert_tick_origin_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(!debTick) |-> !fifoWrReq);
endmodule

bind autorepeatGen arChecker #(
  .CFG_W      (CFG_W),
  .DATA_W     (DATA_W),
  .REPEAT_CODE(REPEAT_CODE)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgByte    (cfgByte),
  .debTick    (debTick),
  .keyEvtValid(keyEvtValid),
  .fifoWrReq  (fifoWrReq),
  .fifoWrData (fifoWrData)
);

// File: tb/tb_autorepeatGen.sv
module tb_autorepeatGen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] cfgByte = 8'h00;
  logic       debTick = 1'b0;
  logic       keyEvtValid = 1'b0;
  logic       keyEvtRelease = 1'b0;
  logic       keyHeld = 1'b0;
  logic       fifoWrReq;
  logic [7:0] fifoWrData;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  string curReq = "R10";

  // Reference model state
  int  mArmed = 0, mRep = 0, mCnt = 0;
  logic mWr = 1'b0;

  always #10 clk = ~clk;

  autorepeatGen dut (
    .clk(clk), .rstN(rstN), .cfgByte(cfgByte), .debTick(debTick),
    .keyEvtValid(keyEvtValid), .keyEvtRelease(keyEvtRelease),
    .keyHeld(keyHeld), .fifoWrReq(fifoWrReq), .fifoWrData(fifoWrData)
  );

  always @(posedge clk) begin
    int tgt;
    if (!rstN) begin
      mArmed = 0; mRep = 0; mCnt = 0; mWr = 1'b0;
    end else begin
      mWr = 1'b0;
      if (!cfgByte[7]) begin
        mArmed = 0; mCnt = 0;
      end else if (keyEvtValid) begin
        mCnt = 0; mRep = 0;
        mArmed = (!keyEvtRelease || keyHeld) ? 1 : 0;
      end else if (!keyHeld) begin
        mArmed = 0;
      end else if (mArmed != 0 && debTick) begin
        mCnt++;
        tgt = (mRep != 0) ? (int'(cfgByte[6:4]) + 1) * 4 : (int'(cfgByte[3:0]) + 1) * 8;
        if (mCnt >= tgt) begin
          mWr = 1'b1; mCnt = 0; mRep = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (fifoWrReq !== mWr) begin
      errors++;
      $display("FAIL %s: fifoWrReq actual %b expected %b at %0t", curReq, fifoWrReq, mWr, $time);
    end
    if (fifoWrReq) begin
      pulses++;
      checks++;
      if (fifoWrData !== 8'h7E) begin
        errors++;
        $display("FAIL R4: fifoWrData actual %h expected 7e", fifoWrData);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      debTick = 1'b1; cyc(); debTick = 1'b0; cyc();
    end
  endtask

  task automatic keyEvt(input logic rel, input logic held, input logic withTick);
    keyEvtValid = 1'b1; keyEvtRelease = rel; keyHeld = held; debTick = withTick;
    cyc();
    keyEvtValid = 1'b0; keyEvtRelease = 1'b0; debTick = 1'b0;
    cyc();
  endtask

  task automatic expectPulses(input string req, input int exp);
    checks++;
    if (pulses != exp) begin
      errors++;
      $display("FAIL %s: pulse count actual %0d expected %0d", req, pulses, exp);
    end
  endtask

  initial begin
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    // R10: idle after reset
    expectPulses("R10", 0);

    // R2 / R3: delay 24, interval 8
    curReq = "R2"; cfgByte = 8'h80 | (8'd1 << 4) | 8'd2; pulses = 0;
    keyEvt(1'b0, 1'b1, 1'b0);
    ticks(23); expectPulses("R2", 0);
    ticks(1);  expectPulses("R2", 1);
    curReq = "R3";
    ticks(7);  expectPulses("R3", 1);
    ticks(1);  expectPulses("R3", 2);
    ticks(8);  expectPulses("R3", 3);

    // R5: second press mid-interval restarts full delay
    curReq = "R5"; pulses = 0;
    ticks(5);
    keyEvt(1'b0, 1'b1, 1'b0);
    ticks(23); expectPulses("R5", 0);
    ticks(1);  expectPulses("R5", 1);

    // R6: release with keys still held restarts; last release stops
    curReq = "R6"; pulses = 0;
    ticks(3);
    keyEvt(1'b1, 1'b1, 1'b0);
    ticks(23); expectPulses("R6", 0);
    ticks(1);  expectPulses("R6", 1);
    keyEvt(1'b1, 1'b0, 1'b0);
    ticks(200); expectPulses("R6", 1);

    // R1: disabled, key held, nothing emitted
    curReq = "R1"; pulses = 0; cfgByte = 8'h00;
    keyEvt(1'b0, 1'b1, 1'b0);
    ticks(200); expectPulses("R1", 0);
    keyEvt(1'b1, 1'b0, 1'b0);

    // R7: clearing enable aborts, re-enable does not resume
    curReq = "R7"; pulses = 0; cfgByte = 8'h80;
    keyEvt(1'b0, 1'b1, 1'b0);
    ticks(5);
    cfgByte = 8'h00; cyc();
    cfgByte = 8'h80; cyc();
    ticks(100); expectPulses("R7", 0);
    // a fresh press after re-enable works with a cleared count
    keyEvt(1'b0, 1'b1, 1'b0);
    ticks(7); expectPulses("R7", 0);
    ticks(1); expectPulses("R7", 1);

    // R8: tick coincident with the press is not counted
    curReq = "R8"; pulses = 0;
    keyEvt(1'b0, 1'b1, 1'b1);
    ticks(7); expectPulses("R8", 0);
    ticks(1); expectPulses("R8", 1);

    // R9: request rises in the cycle after the completing tick edge
    curReq = "R9"; pulses = 0;
    keyEvt(1'b0, 1'b1, 1'b0);
    ticks(7);
    debTick = 1'b1;
    @(posedge clk); #1; debTick = 1'b0;
    checks++;
    if (fifoWrReq !== 1'b1) begin
      errors++;
      $display("FAIL R9: fifoWrReq actual %b expected 1", fifoWrReq);
    end
    cyc();

    // R2 / R3 at the largest fields: 128 then 32
    curReq = "R3"; cfgByte = 8'hFF; pulses = 0;
    keyEvt(1'b0, 1'b1, 1'b0);
    ticks(127); expectPulses("R2", 0);
    ticks(1);   expectPulses("R2", 1);
    ticks(31);  expectPulses("R3", 1);
    ticks(1);   expectPulses("R3", 2);
    keyEvt(1'b1, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: run actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule